// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block sits between a CPU register port and an external analog-to-digital converter. Software programs one 8-bit control register with a channel code, a mode bit, an interrupt enable and a start bit. The block then issues channel numbers and one-cycle start strobes to the converter, and it captures each returned result in a register for that channel. It reports completion through a sticky end flag and a gated interrupt line.

There are two modes. In single mode, exactly one channel is converted and the start bit clears itself. In scan mode, a run of channels inside a four-input group is converted in ascending order, and the run repeats until it is stopped. The run can be stopped by software, by reset, or by the abort input, which stands for the low-power stop conditions.

The end flag is cleared in one of two ways. The first is a read that sees it set, followed by a write of 0. The second is a DMA read of a result, signalled on its own input.

Top module: `adcseq_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, `irq_o` and `conv_start_o` are low, and every result register reads 0.
- R2: Single mode (control bit 4 = 0). Setting the start bit (bit 5) produces exactly one strobe, on the channel given by bits 3..0. The returned result is stored for that channel. The end flag (bit 7) sets, and the start bit clears in the same cycle.
- R3: Scan mode (bit 4 = 1). Channels are strobed in ascending order from `{sel[3:2],2'b00}` up to the selected code `sel`. The end flag sets when the last channel of the run completes, and the run then restarts at the first channel while the start bit stays 1.
- R4: Channel code bit 3 selects the bank of eight, bit 2 selects the group of four within it, and bits 1..0 give the offset in the group. The result for channel `c` reads at address 16+c, zero-extended.
- R5: Writing 0 to bit 7 clears the end flag only if a read of address 0 saw the flag at 1 since the last write. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R6: If the flag is cleared by some other means after such a read and then sets again, a later write of 0 leaves it set.
- R7: A pulse on `dma_rd_i` clears the end flag.
- R8: `irq_o` is high exactly when the end flag and the interrupt enable (bit 6) are both 1.
- R9: Writing the start bit to 0 while a conversion is pending abandons it. A later done pulse stores nothing and leaves the end flag clear.
- R10: Asserting `abort_i` clears the start bit, abandons any pending conversion and stops further strobes.
- R11: While the start bit is 1, writes leave bits 4..0 unchanged. While it is 0, those bits take the written value.
- R12: `conv_start_o` is never high for two consecutive cycles, and `conv_ch_o` holds steady while a conversion is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Stop condition: clears start, abandons conversion |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | 0 = control, 16..31 = result of channel addr-16 |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational on the addressed register |
| dma_rd_i | input | 1 | DMA result read, clears the end flag |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| conv_ch_o | output | 4 | Channel being converted |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | RES_W | Converter result |
| irq_o | output | 1 | Conversion-end interrupt request |

## Verification
The bench builds the block with RES_W = 8 and DATA_W = 16. With those values a generated data pattern stays distinguishable across channels, and stale values are obvious when a read returns the wrong one. The bench sweeps all sixteen channel codes in both modes, so every bank, group and scan length from one to four is covered. In scan mode it follows each run through two full passes. A behavioural converter model with a fixed latency supplies results, and it can also withhold or force done pulses. This lets the bench cover abandonment, abort, frozen configuration and each flag-clearing path, including the re-set race.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CH_W     = 4;
    localparam int GRP_W    = 2;
    localparam int NUM_CH   = 1 << CH_W;
    localparam int ADDR_W   = CH_W + 1;
    localparam int CTRL_W   = 8;
    localparam int START_BIT = 5;
    localparam int FLAG_BIT  = 7;

    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            start;
        logic            scan;
        logic [CH_W-1:0] chsel;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;

    function automatic logic [CH_W-1:0] group_base(input logic [CH_W-1:0] sel);
        return {sel[CH_W-1:GRP_W], {GRP_W{1'b0}}};
    endfunction

    function automatic logic [CH_W-1:0] run_first(input ctrl_t c);
        return c.scan ? group_base(c.chsel) : c.chsel;
    endfunction

    function automatic logic run_last(input ctrl_t c, input logic [CH_W-1:0] cur);
        return !c.scan || (cur == c.chsel);
    endfunction

endpackage

// File: rtl/adcseq_ctrl_reg.sv
module adcseq_ctrl_reg
    import adcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              rd_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              dma_clr,
    input  logic              set_flag,
    input  logic              clr_start,
    input  logic              abort,
    output ctrl_t             ctrl_q
);

    ctrl_t ctrl_n;
    logic  armed_q;
    logic  armed_n;

    always_comb begin
        ctrl_n  = ctrl_q;
        armed_n = armed_q;

        if (rd_ctrl && ctrl_q.flag) begin
            armed_n = 1'b1;
        end

        if (wr_ctrl) begin
            ctrl_n.ie    = wdata[6];
            ctrl_n.start = wdata[START_BIT];
            if (!ctrl_q.start) begin
                ctrl_n.scan  = wdata[4];
                ctrl_n.chsel = wdata[CH_W-1:0];
            end
            if (!wdata[FLAG_BIT] && armed_q && ctrl_q.flag) begin
                ctrl_n.flag = 1'b0;
            end
            armed_n = 1'b0;
        end

        if (dma_clr) begin
            ctrl_n.flag = 1'b0;
        end

        if (clr_start || abort) begin
            ctrl_n.start = 1'b0;
        end

        if (set_flag) begin
            ctrl_n.flag = 1'b1;
        end

        if (!ctrl_n.flag) begin
            armed_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_n;
            armed_q <= armed_n;
        end
    end

endmodule

// File: rtl/adcseq_sequencer.sv
module adcseq_sequencer
    import adcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl_q,
    input  logic            kill,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            res_we,
    output logic            set_flag,
    output logic            clr_start,
    output logic            waiting
);

    sq_state_e       state_q, state_n;
    logic [CH_W-1:0] cur_q, cur_n;

    always_comb begin
        state_n   = state_q;
        cur_n     = cur_q;
        res_we    = 1'b0;
        set_flag  = 1'b0;
        clr_start = 1'b0;

        unique case (state_q)
            SQ_IDLE: begin
                if (ctrl_q.start && !kill) begin
                    state_n = SQ_ISSUE;
                    cur_n   = run_first(ctrl_q);
                end
            end
            SQ_ISSUE: begin
                state_n = kill ? SQ_IDLE : SQ_WAIT;
            end
            SQ_WAIT: begin
                if (kill) begin
                    state_n = SQ_IDLE;
                end else if (conv_done) begin
                    res_we = 1'b1;
                    if (run_last(ctrl_q, cur_q)) begin
                        set_flag = 1'b1;
                        if (ctrl_q.scan) begin
                            cur_n   = run_first(ctrl_q);
                            state_n = SQ_ISSUE;
                        end else begin
                            clr_start = 1'b1;
                            state_n   = SQ_IDLE;
                        end
                    end else begin
                        cur_n   = cur_q + CH_W'(1);
                        state_n = SQ_ISSUE;
                    end
                end
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_n;
            cur_q   <= cur_n;
        end
    end

    assign conv_start = (state_q == SQ_ISSUE);
    assign conv_ch    = cur_q;
    assign waiting    = (state_q == SQ_WAIT);

endmodule

// File: rtl/adcseq_result_bank.sv
module adcseq_result_bank
    import adcseq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] res_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[g] <= '0;
            end else if (we && (wr_idx == CH_W'(g))) begin
                res_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = res_q[rd_idx];

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CTRL_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              dma_rd_i,
    output logic              conv_start_o,
    output logic [CH_W-1:0]   conv_ch_o,
    input  logic              conv_done_i,
    input  logic [RES_W-1:0]  conv_data_i,
    output logic              irq_o
);

    localparam int RES_REGION = ADDR_W - 1;

    ctrl_t             ctrl_q;
    logic [CTRL_W-1:0] ctrl_bits;
    logic              acc_ctrl, acc_res;
    logic              wr_ctrl, rd_ctrl;
    logic              kill;
    logic              res_we, set_flag, clr_start, seq_wait;
    logic [RES_W-1:0]  res_rd;

    assign acc_ctrl = bus_sel_i && (bus_addr_i == '0);
    assign acc_res  = bus_sel_i && bus_addr_i[RES_REGION];
    assign wr_ctrl  = acc_ctrl && bus_wr_i;
    assign rd_ctrl  = acc_ctrl && !bus_wr_i;
    assign kill     = abort_i || (wr_ctrl && !bus_wdata_i[START_BIT]);

    adcseq_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .rd_ctrl   (rd_ctrl),
        .wdata     (bus_wdata_i),
        .dma_clr   (dma_rd_i),
        .set_flag  (set_flag),
        .clr_start (clr_start),
        .abort     (abort_i),
        .ctrl_q    (ctrl_q)
    );

    adcseq_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl_q     (ctrl_q),
        .kill       (kill),
        .conv_done  (conv_done_i),
        .conv_start (conv_start_o),
        .conv_ch    (conv_ch_o),
        .res_we     (res_we),
        .set_flag   (set_flag),
        .clr_start  (clr_start),
        .waiting    (seq_wait)
    );

    adcseq_result_bank #(.RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (res_we),
        .wr_idx  (conv_ch_o),
        .wr_data (conv_data_i),
        .rd_idx  (bus_addr_i[CH_W-1:0]),
        .rd_data (res_rd)
    );

    assign ctrl_bits = ctrl_q;

    always_comb begin
        bus_rdata_o = '0;
        if (acc_ctrl) begin
            bus_rdata_o = DATA_W'(ctrl_bits);
        end else if (acc_res) begin
            bus_rdata_o = DATA_W'(res_rd);
        end
    end

    assign irq_o = ctrl_q.flag && ctrl_q.ie;

endmodule

// File: rtl/adcseq_checks.sv
module adcseq_checks
    import adcseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            abort_i,
    input logic            conv_start_o,
    input logic [CH_W-1:0] conv_ch_o,
    input logic            conv_done_i,
    input ctrl_t           ctrl_q,
    input logic            seq_wait,
    input logic            res_we
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o); // R12

    AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
        (seq_wait && !conv_done_i) |=> $stable(conv_ch_o)); // R12

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!ctrl_q.start && !conv_start_o)); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start |=> $stable({ctrl_q.scan, ctrl_q.chsel})); // R11

    AST_STROBE_IN_SET: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> (ctrl_q.scan
            ? ((conv_ch_o[CH_W-1:GRP_W] == ctrl_q.chsel[CH_W-1:GRP_W]) &&
               (conv_ch_o[GRP_W-1:0] <= ctrl_q.chsel[GRP_W-1:0]))
            : (conv_ch_o == ctrl_q.chsel))); // R3

    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_q.flag) && !ctrl_q.scan) |-> !ctrl_q.start); // R2

    AST_STORE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (seq_wait && conv_done_i && ctrl_q.start)); // R9

endmodule

bind adcseq_top adcseq_checks u_chk (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .conv_done_i  (conv_done_i),
    .ctrl_q       (ctrl_q),
    .seq_wait     (seq_wait),
    .res_we       (res_we)
);

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;

    localparam int RES_W  = 8;
    localparam int DATA_W = 16;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              abort_i = 1'b0;
    logic              bus_sel_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic [4:0]        bus_addr_i = '0;
    logic [7:0]        bus_wdata_i = '0;
    logic [DATA_W-1:0] bus_rdata_o;
    logic              dma_rd_i = 1'b0;
    logic              conv_start_o;
    logic [3:0]        conv_ch_o;
    logic              conv_done_i = 1'b0;
    logic [RES_W-1:0]  conv_data_i = '0;
    logic              irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [RES_W-1:0] exp_res [16];
    logic [3:0]       slog [64];
    int               n_strobe = 0;
    logic             auto_mode = 1'b1;
    logic             force_done = 1'b0;

    always #4 clk = ~clk;

    adcseq_top #(.RES_W(RES_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .abort_i(abort_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .dma_rd_i(dma_rd_i), .conv_start_o(conv_start_o), .conv_ch_o(conv_ch_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .irq_o(irq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // converter model
    initial begin : conv_model
        int   cnt;
        logic [3:0] pend_ch;
        logic prev;
        cnt = 0; pend_ch = '0; prev = 1'b0;
        forever begin
            @(negedge clk);
            conv_done_i = 1'b0;
            if (conv_start_o) begin
                if (prev) begin
                    n_checks++; n_fail++;
                    $display("FAIL R12 actual=strobe_twice expected=single_cycle");
                end
                slog[n_strobe % 64] = conv_ch_o;
                n_strobe++;
                pend_ch = conv_ch_o;
                cnt = LAT;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0 && auto_mode) begin
                    conv_data_i = RES_W'(pend_ch * 13 + n_strobe * 7 + 3);
                    conv_done_i = 1'b1;
                    exp_res[pend_ch] = conv_data_i;
                end
            end
            if (force_done) begin
                conv_data_i = 8'hA5;
                conv_done_i = 1'b1;
                force_done  = 1'b0;
            end
            prev = conv_start_o;
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_sel_i = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        bit seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (irq_o) seen = 1;
        end
        chk(32'(seen), 32'd1, req);
    endtask

    task automatic wait_strobes(input int target);
        for (int i = 0; i < 400 && n_strobe < target; i++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) abort_i = 1'b1; else dma_rd_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0; dma_rd_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [DATA_W-1:0] d;
        int s0;
        for (int i = 0; i < 16; i++) exp_res[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(5'd0, d);  chk(d, 0, "R1 ctrl");
        chk(irq_o, 0, "R1 irq");
        chk(conv_start_o, 0, "R1 strobe");
        bus_rd(5'd16, d); chk(d, 0, "R1 result0");

        // R2/R4/R5/R8 single-mode sweep
        for (int c = 0; c < 16; c++) begin
            s0 = n_strobe;
            bus_wr(5'd0, 8'h60 | 8'(c));
            wait_irq("R2 flag");
            chk(n_strobe - s0, 1, "R2 strobe count");
            chk(slog[s0 % 64], c, "R2 channel");
            bus_rd(5'd0, d); chk(d, 16'hC0 | 16'(c), "R2 ctrl after done");
            bus_wr(5'd0, 8'h40 | 8'(c));
            bus_rd(5'd0, d); chk(d, 16'h40 | 16'(c), "R5 cleared");
            chk(irq_o, 0, "R8 irq low");
            bus_rd(5'(16 + c), d); chk(d, 16'(exp_res[c]), "R4 result");
        end

        // R3/R4 scan-mode sweep
        for (int c = 0; c < 16; c++) begin
            int n, base;
            n = (c & 3) + 1; base = c & 12;
            s0 = n_strobe;
            bus_wr(5'd0, 8'h70 | 8'(c));
            wait_irq("R3 flag");
            wait_strobes(s0 + 2 * n);
            for (int k = 0; k < 2 * n; k++)
                chk(slog[(s0 + k) % 64], base + (k % n), "R3 order");
            auto_mode = 1'b0;
            repeat (8) @(negedge clk);
            bus_wr(5'd0, 8'h50 | 8'(c));
            auto_mode = 1'b1;
            for (int k = 0; k < n; k++) begin
                bus_rd(5'(16 + base + k), d);
                chk(d, 16'(exp_res[base + k]), "R3 result");
            end
            bus_rd(5'd0, d); chk(d, 16'hD0 | 16'(c), "R3 ctrl stopped");
            bus_wr(5'd0, 8'h50 | 8'(c));
            bus_rd(5'd0, d); chk(d, 16'h50 | 16'(c), "R5 cleared scan");
        end

        // R11 configuration frozen while started
        auto_mode = 1'b0;
        s0 = n_strobe;
        bus_wr(5'd0, 8'h63);
        wait_strobes(s0 + 1);
        bus_wr(5'd0, 8'h79);
        bus_rd(5'd0, d); chk(d, 16'h63, "R11 ignored");
        bus_wr(5'd0, 8'h43);
        bus_rd(5'd0, d); chk(d, 16'h43, "R11 stop");
        bus_wr(5'd0, 8'h49);
        bus_rd(5'd0, d); chk(d, 16'h49, "R11 idle write");

        // R9 abandon by writing start 0
        s0 = n_strobe;
        bus_wr(5'd0, 8'h65);
        wait_strobes(s0 + 1);
        bus_wr(5'd0, 8'h45);
        force_done = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(5'd21, d); chk(d, 16'(exp_res[5]), "R9 no store");
        bus_rd(5'd0, d);  chk(d, 16'h45, "R9 no flag");
        chk(irq_o, 0, "R9 irq");

        // R10 abort
        s0 = n_strobe;
        bus_wr(5'd0, 8'h72);
        wait_strobes(s0 + 1);
        pulse(0);
        bus_rd(5'd0, d); chk(d, 16'h52, "R10 start cleared");
        s0 = n_strobe;
        force_done = 1'b1;
        repeat (20) @(negedge clk);
        chk(n_strobe - s0, 0, "R10 no strobes");
        bus_rd(5'd16, d); chk(d, 16'(exp_res[0]), "R10 no store");
        auto_mode = 1'b1;

        // R5/R8 flag clear rules with interrupt disabled then enabled
        s0 = n_strobe;
        bus_wr(5'd0, 8'h27);
        wait_strobes(s0 + 1);
        repeat (LAT + 4) @(negedge clk);
        chk(irq_o, 0, "R8 disabled");
        bus_wr(5'd0, 8'h07);
        bus_rd(5'd0, d); chk(d, 16'h87, "R5 unread write keeps flag");
        bus_wr(5'd0, 8'h87);
        bus_rd(5'd0, d); chk(d, 16'h87, "R5 write one no effect");
        bus_wr(5'd0, 8'hC7);
        chk(irq_o, 1, "R8 enabled");
        bus_rd(5'd0, d);
        bus_wr(5'd0, 8'h47);
        bus_rd(5'd0, d); chk(d, 16'h47, "R5 read then clear");
        chk(irq_o, 0, "R8 low after clear");

        // R7 DMA clear
        bus_wr(5'd0, 8'h68);
        wait_irq("R7 flag");
        pulse(1);
        bus_rd(5'd0, d); chk(d, 16'h48, "R7 dma cleared");
        chk(irq_o, 0, "R7 irq");

        // R6 re-set between read and write
        bus_wr(5'd0, 8'h69);
        wait_irq("R6 flag first");
        bus_rd(5'd0, d); chk(d, 16'hC9, "R6 read");
        pulse(1);
        bus_wr(5'd0, 8'h69);
        wait_irq("R6 flag second");
        bus_wr(5'd0, 8'h49);
        bus_rd(5'd0, d); chk(d, 16'hC9, "R6 flag kept");
        chk(irq_o, 1, "R6 irq kept");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule